// File: doc/BRIEF.md
# Flash single-word program sequencer

This block is the device-side command engine of a parallel NOR-style memory. A host writes command codes and data through an active-low write strobe. Each command is taken when the strobe goes from low to high, using the address and data present at that moment. A program command followed by one address/data write programs a single word of a small register-modelled array. The operation takes a fixed number of clock cycles. During that time a ready pin is low, and reads return either the status register or, if array reads were selected meanwhile, invalid data.

Before a program starts, the block checks the lock bit of the addressed block and a program-enable input. The enable input must then stay valid for every cycle of the operation. A violation aborts the operation without touching the array and sets error bits that stay set until a clear-status command is written. A reset asserted during programming aborts it. The addressed word then holds an undefined mix of its old and new bits: bits can only be cleared, never set.

Command codes sit in data bits 7:0. 0x40 starts a program, 0x70 selects status reads, 0xFF selects array reads and 0x50 clears the status error bits. The array is split into equal blocks, and the top address bits select the block.

Top module: `flash_word_prog`

## Requirements
- R1: After reset, rdy is 1, reads return array data (the array is all ones at power-up), and the status register reads 0x0080.
- R2: A write of 0x40 followed by an address/data write programs that word to old & data. Other words are unchanged.
- R3: rdy (and status bit 7) is 0 for exactly PROG_CYC clock cycles after an accepted data write, then returns to 1.
- R4: Once 0x40 is written, reads return the status register, zero-extended to DW bits, until 0xFF is written. 0x70 also selects status reads.
- R5: A data write to a block whose lock bit is 1 programs nothing, keeps rdy at 1 and sets status bits 1 and 4 (status 0x92).
- R6: If the enable input is low at the data write, or in any cycle of the busy period, the word is unchanged and status bits 3 and 4 are set (status 0x98).
- R7: Status bits 4, 3 and 1 stay set until 0x50 is written, which clears them. Status bits 6, 5, 2 and 0 always read 0.
- R8: If 0xFF is written while programming, array reads return the bitwise inverse of the stored word until programming ends, and true data afterwards.
- R9: Reset during programming aborts it. rdy returns to 1, reads return array data and the status register reads 0x0080. The addressed word gains no 1 bits, and other words are unchanged.
- R10: A write of any other code while idle changes neither the read mode nor the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; aborts programming |
| we_n | input | 1 | Active-low write strobe; its rising edge takes a write |
| addr | input | AW | Word address for writes and reads |
| din | input | DW | Write data; command code in bits 7:0 |
| vpen | input | 1 | Program-enable (supply valid) |
| lock | input | BLKS | Lock bit per block |
| dout | output | DW | Read data (array, status or invalid) |
| rdy | output | 1 | High when not programming |

## Verification
On every cycle, the assertions check three things: error bits 3 and 1 never appear without bit 4, and the error bits stay set unless a clear-status command arrives. They also check that a locked data write never enters the busy period, that an accepted data write leaves the block busy in status mode, and that every completed program only clears bits. The bench alone shows the exact busy length, the read-mode switching, the inverted array data during busy, the reset abort outcome and the ignoring of unknown codes. It does this through directed corner cases plus randomised programs against a model of the array.

// File: rtl/flash_word_prog.sv
module flash_word_prog #(
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter int BLKS     = 4,
  parameter int PROG_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   din,
  input  logic            vpen,
  input  logic [BLKS-1:0] lock,
  output logic [DW-1:0]   dout,
  output logic            rdy
);
  localparam int DEPTH = 1 << AW;
  localparam int BW    = $clog2(BLKS);
  localparam int CW    = $clog2(PROG_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_BUSY} st_t;

  st_t           st;
  logic          rd_stat, we_q, vfail;
  logic          e_prog, e_vpp, e_lock;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [DW-1:0] mem [DEPTH] = '{default: '1};
  logic [7:0]    sr;

  wire          wr_ev = we_n & ~we_q;
  wire [7:0]    cmd   = din[7:0];
  wire [BW-1:0] blk   = addr[AW-1 -: BW];
  wire          busy  = (st == S_BUSY);
  wire          done  = busy && (cnt == '0);
  wire          commit = done && vpen && !vfail;
  wire [DW-1:0] cur_word = mem[a_q];

  assign sr   = {~busy, 2'b00, e_prog, e_vpp, 1'b0, e_lock, 1'b0};
  assign rdy  = ~busy;
  assign dout = rd_stat ? {{(DW-8){1'b0}}, sr} : (busy ? ~mem[addr] : mem[addr]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rd_stat <= 1'b0;
      we_q    <= 1'b1;
      vfail   <= 1'b0;
      e_prog  <= 1'b0;
      e_vpp   <= 1'b0;
      e_lock  <= 1'b0;
      cnt     <= '0;
    end else begin
      we_q <= we_n;
      case (st)
        S_IDLE: if (wr_ev) begin
          case (cmd)
            8'h40: begin st <= S_ARM; rd_stat <= 1'b1; end
            8'h70: rd_stat <= 1'b1;
            8'hFF: rd_stat <= 1'b0;
            8'h50: begin e_prog <= 1'b0; e_vpp <= 1'b0; e_lock <= 1'b0; end
            default: ;
          endcase
        end
        S_ARM: if (wr_ev) begin
          if (lock[blk] || !vpen) begin
            e_prog <= 1'b1;
            if (lock[blk]) e_lock <= 1'b1;
            if (!vpen)     e_vpp  <= 1'b1;
            st <= S_IDLE;
          end else begin
            st    <= S_BUSY;
            cnt   <= CW'(PROG_CYC - 1);
            vfail <= 1'b0;
          end
        end
        S_BUSY: begin
          if (!vpen) vfail <= 1'b1;
          if (wr_ev && cmd == 8'h70) rd_stat <= 1'b1;
          if (wr_ev && cmd == 8'hFF) rd_stat <= 1'b0;
          if (cnt == '0) begin
            st <= S_IDLE;
            if (vfail || !vpen) begin
              e_prog <= 1'b1;
              e_vpp  <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (st == S_ARM && wr_ev) begin
      a_q <= addr;
      d_q <= din;
    end

  always_ff @(posedge clk)
    if (busy && (!rst_n || commit))
      mem[a_q] <= cur_word & d_q;

  p_err_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (e_vpp || e_lock) |-> e_prog);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (e_prog && !(st == S_IDLE && wr_ev && cmd == 8'h50)) |=> e_prog);

  p_lock_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARM && wr_ev && lock[blk]) |=> (rdy && e_lock && st == S_IDLE));

  p_enter_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARM && wr_ev && !lock[blk] && vpen) |=> (!rdy && rd_stat));

  p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (mem[$past(a_q)] == ($past(cur_word) & $past(d_q))));
endmodule

// File: tb/tb_flash_word_prog.sv
`timescale 1ns/1ps
module tb_flash_word_prog;
  localparam int AW = 6, DW = 16, BLKS = 4, PROG_CYC = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, we_n = 1, vpen = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [BLKS-1:0] lock = 4'b0100;
  logic [DW-1:0] dout;
  logic rdy;
  logic [DW-1:0] model [DEPTH];
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_word_prog #(.AW(AW), .DW(DW), .BLKS(BLKS), .PROG_CYC(PROG_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .din(din),
    .vpen(vpen), .lock(lock), .dout(dout), .rdy(rdy));

  function automatic logic [DW-1:0] exp_sr(bit lk, bit vok);
    logic [DW-1:0] s = 16'h0080;
    if (lk)  s |= 16'h0012;
    if (!vok) s |= 16'h0018;
    return s;
  endfunction

  function automatic bit is_locked(logic [AW-1:0] a);
    return lock[a[AW-1 -: 2]];
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; din = d; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    addr = a; #0.5; v = dout;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rdy && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int n;
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rdy", {15'b0, rdy}, 16'h1);
    rd(0, v); check("R1 array mode", v, 16'hFFFF);
    wr(0, 16'h70); rd(0, v); check("R1 status", v, 16'h0080);
    wr(0, 16'hFF);

    // R2 R3 R4 basic program
    wr(0, 16'h40); rd(5, v); check("R4 status after 0x40", v, 16'h0080);
    wr(5, 16'h1234);
    wait_rdy(n); check("R3 busy length", 16'(n), 16'(PROG_CYC));
    rd(5, v); check("R4 status kept after program", v, 16'h0080);
    wr(0, 16'hFF); model[5] &= 16'h1234;
    rd(5, v); check("R2 programmed word", v, model[5]);
    rd(4, v); check("R2 neighbour unchanged", v, model[4]);

    // R8 read array during busy
    wr(0, 16'h40); wr(6, 16'h00F0); wr(0, 16'hFF);
    check("R8 still busy", {15'b0, rdy}, 16'h0);
    rd(6, v); check("R8 invalid data", v, ~model[6]);
    wait_rdy(n); model[6] &= 16'h00F0;
    rd(6, v); check("R8 valid after done", v, model[6]);

    // R5 locked block
    wr(0, 16'h40); wr(35, 16'h0000);
    check("R5 rdy stays", {15'b0, rdy}, 16'h1);
    rd(35, v); check("R5 status", v, 16'h0092);
    // R7 sticky
    wr(0, 16'hFF); rd(35, v); check("R5 word unchanged", v, model[35]);
    wr(0, 16'h70); rd(0, v); check("R7 sticky", v, 16'h0092);
    wr(0, 16'h50); rd(0, v); check("R7 cleared", v, 16'h0080);

    // R6 enable low at data write
    vpen = 0; wr(0, 16'h40); wr(7, 16'h0000); vpen = 1;
    rd(7, v); check("R6 status at write", v, 16'h0098);
    wr(0, 16'h50);
    // R6 enable dip mid-busy
    wr(0, 16'h40); wr(8, 16'h0000);
    repeat (3) @(negedge clk); vpen = 0; @(negedge clk); vpen = 1;
    wait_rdy(n); rd(0, v); check("R6 status mid-busy", v, 16'h0098);
    wr(0, 16'hFF); rd(8, v); check("R6 word unchanged", v, model[8]);
    wr(0, 16'h50);

    // R10 ignored codes
    wr(0, 16'h0012); rd(5, v); check("R10 mode kept", v, model[5]);
    wr(0, 16'h70); wr(0, 16'h0033); rd(0, v); check("R10 status kept", v, 16'h0080);
    wr(0, 16'hFF);

    // R9 reset abort
    wr(0, 16'h40); wr(9, 16'h0F0F);
    repeat (3) @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    check("R9 rdy", {15'b0, rdy}, 16'h1);
    rd(9, v); check("R9 no new ones", v & ~model[9], 16'h0000); model[9] = v;
    rd(10, v); check("R9 other word", v, model[10]);
    wr(0, 16'h70); rd(0, v); check("R9 status", v, 16'h0080);
    wr(0, 16'hFF);

    // random programs
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a = AW'($urandom % DEPTH);
      logic [DW-1:0] d = DW'($urandom);
      bit vok = ($urandom % 6) != 0;
      bit lk = is_locked(a);
      vpen = vok;
      wr(0, 16'h40); wr(a, d);
      wait_rdy(n); vpen = 1;
      if (!lk && vok) check("R3 random busy length", 16'(n), 16'(PROG_CYC));
      rd(a, v); check("R7 random status", v, exp_sr(lk, vok));
      if (!lk && vok) model[a] &= d;
      wr(0, 16'hFF); rd(a, v); check("R2 random word", v, model[a]);
      wr(0, 16'h50);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule